// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of a single-precision fused multiply-add datapath. It looks at the three operands of `z + x*y`, or `z - x*y` when the negate-product control is set, and decides whether the answer can be settled without any arithmetic. NaN operands, infinities, invalid combinations such as infinity times zero, and products that are exactly zero are all resolved here. The block drives a final early result and an invalid-operation flag for these cases.

When the multiplicands are both finite and nonzero and the addend is finite, no special rule applies. The block then raises `proceed`, and the arithmetic pipeline computes, normalises and rounds the true sum. The block is purely combinational, so its outputs follow its inputs in the same cycle. The rounding mode matters only for the sign of an exact zero sum.

Top module: `fmaSpecialResolve`

## Requirements
- R1: When x and y are both finite and nonzero (normal or denormal) and z is finite, the block drives proceed=1, earlyValid=0, invalidOp=0 and earlyResult=0.
- R2: If any operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the first such operand in the order z, x, y is returned with bit 22 set and its sign and other payload bits kept, and invalidOp=1.
- R3: With no signalling NaN present, the first quiet NaN (exponent all ones, bit 22 set) in the order z, x, y is returned unchanged with invalidOp=0.
- R4: With no NaN present, if one multiplicand is infinite and the other is zero, the result is 0x7FC00000 and invalidOp=1.
- R5: With no NaN present and an infinite product, if z is infinite with a sign different from the effective product sign (x.sign XOR y.sign XOR negProd), the result is 0x7FC00000 and invalidOp=1.
- R6: With no NaN present and an infinite product that is not invalid, the result is infinity with the effective product sign, and invalidOp=0.
- R7: With a zero product and z infinite, or z finite and nonzero, the result is z unchanged.
- R8: With a zero product and z zero, the result is z when z's sign equals the effective product sign. Otherwise it is a zero whose sign is 1 only when rndMode=3 (toward minus infinity), with encodings 0 nearest, 1 toward zero, 2 toward plus infinity.
- R9: When x and y are finite and nonzero and z is infinite, the result is z unchanged with invalidOp=0.
- R10: Exactly one of earlyValid and proceed is high for every input, and invalidOp is high only together with earlyValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opZ | input | 32 | Addend, single precision |
| opX | input | 32 | First multiplicand |
| opY | input | 32 | Second multiplicand |
| negProd | input | 1 | Subtract the product instead of adding it |
| rndMode | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| earlyResult | output | 32 | Resolved result, zero when proceed is high |
| earlyValid | output | 1 | earlyResult is the final answer |
| invalidOp | output | 1 | Invalid-operation exception |
| proceed | output | 1 | No special case; the arithmetic datapath must compute |

## Verification
Every output is a combinational function of the current operands, so each result is due in the same cycle that the operands are applied, with zero register stages. The bench changes the operands on the falling clock edge and samples the outputs two nanoseconds later, which is well before the next rising edge. Expected values come from a bench function that applies the priority rules in order. Directed vectors cover the rules at their boundaries, and a seeded random mix of operand classes covers the combinations between them.

// File: rtl/fmaResolvePkg.sv
package fmaResolvePkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic qnan;
    logic snan;
  } opClass_t;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_Z     = 3'd1,
    SRC_X     = 3'd2,
    SRC_Y     = 3'd3,
    SRC_INDEF = 3'd4,
    SRC_INF   = 3'd5,
    SRC_ZERO  = 3'd6
  } srcSel_e;

  typedef struct packed {
    srcSel_e srcSel;
    logic    setQuiet;
    logic    signBit;
    logic    valid;
    logic    invalid;
    logic    proceed;
  } ctrlStrobe_t;
endpackage

// File: rtl/fmaOpClassify.sv
module fmaOpClassify
  import fmaResolvePkg::*;
#(
  parameter int EXP_BITS  = EXP_W,
  parameter int FRAC_BITS = FRAC_W
) (
  input  logic [EXP_BITS+FRAC_BITS:0] opIn,
  output opClass_t                    opCls
);
  localparam int TOP = EXP_BITS + FRAC_BITS;

  logic expOnes;
  logic expZero;
  logic fracZero;

  always_comb begin
    expOnes  = &opIn[TOP-1:FRAC_BITS];
    expZero  = ~|opIn[TOP-1:FRAC_BITS];
    fracZero = ~|opIn[FRAC_BITS-1:0];
    opCls.sign = opIn[TOP];
    opCls.zero = expZero & fracZero;
    opCls.inf  = expOnes & fracZero;
    opCls.qnan = expOnes & opIn[FRAC_BITS-1];
    opCls.snan = expOnes & ~fracZero & ~opIn[FRAC_BITS-1];
  end
endmodule

// File: rtl/fmaResolveCtrl.sv
module fmaResolveCtrl
  import fmaResolvePkg::*;
(
  input  opClass_t    clsZ,
  input  opClass_t    clsX,
  input  opClass_t    clsY,
  input  logic        negProd,
  input  logic [1:0]  rndMode,
  output ctrlStrobe_t strobe
);
  logic prodSign;
  logic prodInf;
  logic prodZero;
  logic anyNan;

  always_comb begin
    prodSign = clsX.sign ^ clsY.sign ^ negProd;
    prodInf  = clsX.inf | clsY.inf;
    prodZero = clsX.zero | clsY.zero;
    anyNan   = clsZ.qnan | clsZ.snan | clsX.qnan | clsX.snan | clsY.qnan | clsY.snan;

    strobe = '{srcSel: SRC_NONE, setQuiet: 1'b0, signBit: 1'b0,
               valid: 1'b1, invalid: 1'b0, proceed: 1'b0};

    if (clsZ.snan) begin
      strobe.srcSel = SRC_Z; strobe.setQuiet = 1'b1; strobe.invalid = 1'b1;
    end else if (clsX.snan) begin
      strobe.srcSel = SRC_X; strobe.setQuiet = 1'b1; strobe.invalid = 1'b1;
    end else if (clsY.snan) begin
      strobe.srcSel = SRC_Y; strobe.setQuiet = 1'b1; strobe.invalid = 1'b1;
    end else if (clsZ.qnan) begin
      strobe.srcSel = SRC_Z;
    end else if (clsX.qnan) begin
      strobe.srcSel = SRC_X;
    end else if (clsY.qnan) begin
      strobe.srcSel = SRC_Y;
    end else if (prodInf && prodZero) begin
      strobe.srcSel = SRC_INDEF; strobe.invalid = 1'b1;
    end else if (prodInf) begin
      if (clsZ.inf && (clsZ.sign != prodSign)) begin
        strobe.srcSel = SRC_INDEF; strobe.invalid = 1'b1;
      end else begin
        strobe.srcSel = SRC_INF; strobe.signBit = prodSign;
      end
    end else if (prodZero) begin
      if (clsZ.zero && (clsZ.sign != prodSign)) begin
        strobe.srcSel  = SRC_ZERO;
        strobe.signBit = (rndMode == 2'd3);
      end else begin
        strobe.srcSel = SRC_Z;
      end
    end else if (clsZ.inf) begin
      strobe.srcSel = SRC_Z;
    end else begin
      strobe.valid   = 1'b0;
      strobe.proceed = 1'b1;
    end
  end

  always_comb begin
    if (anyNan) begin
      AST_NAN_RESOLVED: assert (strobe.valid && !strobe.proceed); // R3
    end
    if (!anyNan && prodInf && prodZero) begin
      AST_INF_TIMES_ZERO: assert (strobe.invalid && strobe.srcSel == SRC_INDEF); // R4
    end
  end
endmodule

// File: rtl/fmaResolveDatapath.sv
module fmaResolveDatapath
  import fmaResolvePkg::*;
#(
  parameter int EXP_BITS  = EXP_W,
  parameter int FRAC_BITS = FRAC_W
) (
  input  logic [EXP_BITS+FRAC_BITS:0] opZ,
  input  logic [EXP_BITS+FRAC_BITS:0] opX,
  input  logic [EXP_BITS+FRAC_BITS:0] opY,
  input  ctrlStrobe_t                 strobe,
  output logic [EXP_BITS+FRAC_BITS:0] earlyResult,
  output logic                        earlyValid,
  output logic                        invalidOp,
  output logic                        proceed
);
  localparam int TOP = EXP_BITS + FRAC_BITS;

  logic [TOP:0] picked;

  always_comb begin
    unique case (strobe.srcSel)
      SRC_Z:     picked = opZ;
      SRC_X:     picked = opX;
      SRC_Y:     picked = opY;
      SRC_INDEF: picked = {1'b0, {EXP_BITS{1'b1}}, 1'b1, {(FRAC_BITS-1){1'b0}}};
      SRC_INF:   picked = {strobe.signBit, {EXP_BITS{1'b1}}, {FRAC_BITS{1'b0}}};
      SRC_ZERO:  picked = {strobe.signBit, {TOP{1'b0}}};
      default:   picked = '0;
    endcase
    if (strobe.setQuiet) picked[FRAC_BITS-1] = 1'b1;
    earlyResult = strobe.valid ? picked : '0;
    earlyValid  = strobe.valid;
    invalidOp   = strobe.invalid & strobe.valid;
    proceed     = strobe.proceed;
  end

  always_comb begin
    AST_ONE_OUTCOME: assert (earlyValid ^ proceed); // R10
    if (invalidOp) begin
      AST_INVALID_GIVES_QNAN: assert ((&earlyResult[TOP-1:FRAC_BITS]) && earlyResult[FRAC_BITS-1]); // R2
    end
    if (proceed) begin
      AST_PROCEED_CLEAR: assert (earlyResult == '0 && !invalidOp); // R1
    end
  end
endmodule

// File: rtl/fmaSpecialResolve.sv
module fmaSpecialResolve
  import fmaResolvePkg::*;
(
  input  logic [31:0] opZ,
  input  logic [31:0] opX,
  input  logic [31:0] opY,
  input  logic        negProd,
  input  logic [1:0]  rndMode,
  output logic [31:0] earlyResult,
  output logic        earlyValid,
  output logic        invalidOp,
  output logic        proceed
);
  opClass_t    cls [3];
  ctrlStrobe_t strobe;
  logic [WORD_W-1:0] ops [3];

  assign ops[0] = opZ;
  assign ops[1] = opX;
  assign ops[2] = opY;

  for (genvar i = 0; i < 3; i++) begin : g_cls
    fmaOpClassify #(.EXP_BITS(EXP_W), .FRAC_BITS(FRAC_W)) classify_i (
      .opIn  (ops[i]),
      .opCls (cls[i])
    );
  end

  fmaResolveCtrl ctrl_i (
    .clsZ    (cls[0]),
    .clsX    (cls[1]),
    .clsY    (cls[2]),
    .negProd (negProd),
    .rndMode (rndMode),
    .strobe  (strobe)
  );

  fmaResolveDatapath #(.EXP_BITS(EXP_W), .FRAC_BITS(FRAC_W)) dp_i (
    .opZ         (opZ),
    .opX         (opX),
    .opY         (opY),
    .strobe      (strobe),
    .earlyResult (earlyResult),
    .earlyValid  (earlyValid),
    .invalidOp   (invalidOp),
    .proceed     (proceed)
  );
endmodule

// File: tb/fmaSpecialResolve_tb.sv
module fmaSpecialResolve_tb_top;
  logic        clk = 1'b0;
  logic [31:0] opZ = '0, opX = '0, opY = '0;
  logic        negProd = 1'b0;
  logic [1:0]  rndMode = 2'd0;
  logic [31:0] earlyResult;
  logic        earlyValid, invalidOp, proceed;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fmaSpecialResolve dut_i (
    .opZ(opZ), .opX(opX), .opY(opY), .negProd(negProd), .rndMode(rndMode),
    .earlyResult(earlyResult), .earlyValid(earlyValid),
    .invalidOp(invalidOp), .proceed(proceed)
  );

  function automatic bit fIsNan(input logic [31:0] a); return (&a[30:23]) && (|a[22:0]); endfunction
  function automatic bit fIsSnan(input logic [31:0] a); return fIsNan(a) && !a[22]; endfunction
  function automatic bit fIsQnan(input logic [31:0] a); return fIsNan(a) && a[22]; endfunction
  function automatic bit fIsInf(input logic [31:0] a); return (&a[30:23]) && (a[22:0] == 0); endfunction
  function automatic bit fIsZero(input logic [31:0] a); return a[30:0] == 0; endfunction

  function automatic void refModel(input logic [31:0] z, x, y, input logic n, input logic [1:0] rm,
                                   output logic [31:0] r, output logic v, output logic inv,
                                   output string tag);
    logic ps;
    ps = x[31] ^ y[31] ^ n;
    v = 1'b1; inv = 1'b0; r = '0;
    if (fIsSnan(z))      begin r = z | 32'h0040_0000; inv = 1; tag = "R2"; end
    else if (fIsSnan(x)) begin r = x | 32'h0040_0000; inv = 1; tag = "R2"; end
    else if (fIsSnan(y)) begin r = y | 32'h0040_0000; inv = 1; tag = "R2"; end
    else if (fIsQnan(z)) begin r = z; tag = "R3"; end
    else if (fIsQnan(x)) begin r = x; tag = "R3"; end
    else if (fIsQnan(y)) begin r = y; tag = "R3"; end
    else if ((fIsInf(x) && fIsZero(y)) || (fIsZero(x) && fIsInf(y))) begin
      r = 32'h7FC0_0000; inv = 1; tag = "R4";
    end else if (fIsInf(x) || fIsInf(y)) begin
      if (fIsInf(z) && z[31] != ps) begin r = 32'h7FC0_0000; inv = 1; tag = "R5"; end
      else begin r = {ps, 8'hFF, 23'd0}; tag = "R6"; end
    end else if (fIsZero(x) || fIsZero(y)) begin
      if (fIsZero(z)) begin
        tag = "R8";
        r = (z[31] == ps) ? z : {(rm == 2'd3), 31'd0};
      end else begin r = z; tag = "R7"; end
    end else if (fIsInf(z)) begin r = z; tag = "R9"; end
    else begin v = 0; tag = "R1"; end
  endfunction

  function automatic logic [31:0] mkOp(input int cls);
    logic s; logic [22:0] f; logic [7:0] e;
    s = 1'($urandom); f = 23'($urandom);
    case (cls)
      0: return {s, 31'd0};
      1: return {s, 8'd0, (f == 0) ? 23'd1 : f};
      3: return {s, 8'hFF, 23'd0};
      4: return {s, 8'hFF, 1'b1, f[21:0]};
      5: return {s, 8'hFF, 1'b0, (f[21:0] == 0) ? 22'd1 : f[21:0]};
      default: begin
        e = 8'($urandom_range(254, 1));
        return {s, e, f};
      end
    endcase
  endfunction

  task automatic applyCheck(input logic [31:0] z, x, y, input logic n, input logic [1:0] rm);
    logic [31:0] er; logic ev, ei; string tag;
    @(negedge clk);
    opZ = z; opX = x; opY = y; negProd = n; rndMode = rm;
    #2;
    refModel(z, x, y, n, rm, er, ev, ei, tag);
    checks++;
    if (earlyResult !== er || earlyValid !== ev || invalidOp !== ei || proceed !== !ev) begin
      errors++;
      $display("FAIL %s: z=%h x=%h y=%h n=%0d rm=%0d got res=%h v=%b inv=%b pr=%b exp res=%h v=%b inv=%b pr=%b",
               tag, z, x, y, n, rm, earlyResult, earlyValid, invalidOp, proceed, er, ev, ei, !ev);
    end
    checks++;
    if ((earlyValid ^ proceed) !== 1'b1 || (invalidOp && !earlyValid)) begin
      errors++;
      $display("FAIL R10: got v=%b pr=%b inv=%b exp exactly one of v/pr, inv only with v",
               earlyValid, proceed, invalidOp);
    end
  endtask

  initial begin
    #2;
    // all-zero inputs: +0 + (+0 * +0) gives +0 (R8)
    checks++;
    if (earlyResult !== 32'h0 || earlyValid !== 1'b1 || invalidOp !== 1'b0 || proceed !== 1'b0) begin
      errors++;
      $display("FAIL R8: idle got res=%h v=%b exp res=00000000 v=1", earlyResult, earlyValid);
    end
    void'($urandom(32'h5eed_1234));
    // R2: priority z, x, y among signalling NaNs; sNaN beats qNaN
    applyCheck(32'hFF80_0123, 32'h7F80_0001, 32'h7FA0_0000, 1'b0, 2'd0);
    applyCheck(32'h7FC0_0005, 32'h7F80_0001, 32'h7FA0_0000, 1'b0, 2'd0);
    applyCheck(32'h3F80_0000, 32'h7FE0_0000, 32'hFF80_0042, 1'b1, 2'd0);
    // R3: quiet NaN priority
    applyCheck(32'h3F80_0000, 32'hFFC0_0011, 32'h7FC0_0022, 1'b0, 2'd0);
    applyCheck(32'h7FC1_0000, 32'hFFC0_0011, 32'h0000_0000, 1'b0, 2'd0);
    // R4: inf times zero, including with z infinite
    applyCheck(32'h3F80_0000, 32'h7F80_0000, 32'h8000_0000, 1'b0, 2'd0);
    applyCheck(32'hFF80_0000, 32'h0000_0000, 32'hFF80_0000, 1'b1, 2'd0);
    // R5: opposite-sign infinities, with and without negation
    applyCheck(32'hFF80_0000, 32'h7F80_0000, 32'h3F80_0000, 1'b0, 2'd0);
    applyCheck(32'h7F80_0000, 32'h7F80_0000, 32'h3F80_0000, 1'b1, 2'd0);
    // R6: valid infinite product
    applyCheck(32'h7F80_0000, 32'h7F80_0000, 32'h3F80_0000, 1'b0, 2'd0);
    applyCheck(32'h4000_0000, 32'h0000_0001, 32'hFF80_0000, 1'b1, 2'd0);
    // R7: zero product
    applyCheck(32'hFF80_0000, 32'h0000_0000, 32'h4000_0000, 1'b0, 2'd0);
    applyCheck(32'h0000_0003, 32'h8000_0000, 32'h4000_0000, 1'b1, 2'd0);
    // R8: signed zero sums under each rounding mode
    applyCheck(32'h8000_0000, 32'h8000_0000, 32'h3F80_0000, 1'b0, 2'd0);
    applyCheck(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 1'b0, 2'd3);
    applyCheck(32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 1'b0, 2'd2);
    applyCheck(32'h0000_0000, 32'h0000_0000, 32'h3F80_0000, 1'b1, 2'd3);
    applyCheck(32'h8000_0000, 32'h0000_0000, 32'h3F80_0000, 1'b1, 2'd1);
    // R9 and R1
    applyCheck(32'hFF80_0000, 32'h3F80_0000, 32'h0000_0001, 1'b0, 2'd0);
    applyCheck(32'h4040_0000, 32'h3F80_0000, 32'h0000_0001, 1'b0, 2'd0);
    applyCheck(32'h0000_0000, 32'h7F7F_FFFF, 32'h8080_0000, 1'b1, 2'd3);
    // random mix of operand classes
    for (int i = 0; i < 4000; i++) begin
      int cz, cx, cy;
      cz = $urandom_range(8, 0); cx = $urandom_range(8, 0); cy = $urandom_range(8, 0);
      applyCheck(mkOp(cz), mkOp(cx), mkOp(cy), 1'($urandom), 2'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule